// File: doc/BRIEF.md
# Serial-to-Parallel Shift and Hold Register

This block gathers a serial bit stream into a parallel word. Each cycle in which the shift strobe is high, one bit from the serial input is pushed into a chain of shift stages. The last stage is always visible on a cascade output, so several instances can be chained into one longer register. A separate store strobe copies the whole chain, all stages in the same cycle, into a hold register. That register drives the parallel output, so the output stays steady while the next word is shifted in.

Both strobes are sampled on one system clock. The shift chain and the hold register each have their own active-low clear. A clear acts at once and asynchronously, and it touches only its own register. Its release is synchronised to the clock. The strobes are plain single-cycle enables with no handshake: the block accepts a bit or a store on every cycle in which it is asked to. No back-pressure exists, and the source must not expect any.

Top module: `sipo_latch_top`

## Requirements
- R1: While both clears are low, `par_out` is all zeros and `casc_out` is 0.
- R2: On a clock edge with `shift_stb` high, stage 0 takes `ser_in` and every stage k>0 takes the old value of stage k-1, without inversion. When two instances are chained through `casc_out`, 16 bits sent last-bit-first appear as one word: the second instance's `par_out` holds bits 15..8 and the first instance's holds bits 7..0.
- R3: `casc_out` always equals the highest shift stage. After a shift it carries what the second-highest stage held before the edge, and it does not change on edges without a shift.
- R4: `par_out` changes only on an edge with `store_stb` high, or through the store clear.
- R5: Pulling `shift_clr_n` low forces every shift stage, and so `casc_out`, to 0 at once. `par_out` is left unchanged.
- R6: Pulling `store_clr_n` low forces `par_out` to 0 at once. The shift stages are left unchanged, and a later store shows their contents.
- R7: A store made after the shift chain has been cleared loads all zeros.
- R8: When both strobes are high on the same edge, the shift chain advances and the hold register captures the chain's contents from before that edge.
- R9: While a clear is held low, its register stays at zero and ignores its own strobe.
- R10: A clear's release is synchronised over SYNC_STAGES clock edges (default 2). Strobes on those edges are ignored, and the register acts on the strobe at edge SYNC_STAGES+1 after the clear input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| shift_clr_n | input | 1 | Active-low asynchronous clear of the shift chain |
| store_clr_n | input | 1 | Active-low asynchronous clear of the hold register |
| ser_in | input | 1 | Serial data bit |
| shift_stb | input | 1 | Shift enable, one cycle per bit |
| store_stb | input | 1 | Copy-chain-to-output enable |
| par_out | output | W | Parallel output from the hold register |
| casc_out | output | 1 | Highest shift stage, for chaining |

## Verification
The main path is driven through two chained instances with 256 sixteen-bit words. These are every single-one word, every single-zero word, and a set of arithmetic mixes. The single-one words expose any misplaced or swapped stage, including a bit lost across the cascade link. The single-zero words expose stages that stick at one or invert. Before each store, the previous word is compared against the output, which separates a correct hold from a register that follows the chain. Separate sequences cover same-edge shift and store, each clear alone, and the exact edge on which a released clear starts to accept strobes.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned SIPO_WIDTH_DEFAULT = 8;
  localparam int unsigned SIPO_SYNC_DEFAULT  = 2;
endpackage

// File: rtl/sipo_clr_release.sv
// Clear conditioner: asserts immediately, releases after STAGES edges.
module sipo_clr_release #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n_in,
  output logic live
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge clr_n_in) begin
    if (!clr_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign live = sync_q[STAGES-1];
endmodule

// File: rtl/sipo_shift_chain.sv
// Shift stages: stage 0 takes the serial bit, the rest move up by one.
module sipo_shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         live,
  input  logic         stb,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge live) begin
    if (!live)    q <= '0;
    else if (stb) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/sipo_hold_reg.sv
// Parallel hold register loaded from the shift chain on a store strobe.
module sipo_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         live,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge live) begin
    if (!live)     q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sipo_latch_top.sv
module sipo_latch_top #(
  parameter int unsigned W           = sipo_pkg::SIPO_WIDTH_DEFAULT,
  parameter int unsigned SYNC_STAGES = sipo_pkg::SIPO_SYNC_DEFAULT
) (
  input  logic         clk,
  input  logic         shift_clr_n,
  input  logic         store_clr_n,
  input  logic         ser_in,
  input  logic         shift_stb,
  input  logic         store_stb,
  output logic [W-1:0] par_out,
  output logic         casc_out
);
  localparam int unsigned NUM_CLR = 2;
  localparam int unsigned TOP_BIT = W - 1;

  logic [NUM_CLR-1:0] clr_in_n;
  logic [NUM_CLR-1:0] live_vec;
  logic [W-1:0]       shift_bits;

  assign clr_in_n = {store_clr_n, shift_clr_n};

  // index 0: shift chain, index 1: hold register
  for (genvar g = 0; g < NUM_CLR; g++) begin : g_clr
    sipo_clr_release #(.STAGES(SYNC_STAGES)) u_rel (
      .clk      (clk),
      .clr_n_in (clr_in_n[g]),
      .live     (live_vec[g])
    );
  end

  sipo_shift_chain #(.W(W)) u_chain (
    .clk  (clk),
    .live (live_vec[0]),
    .stb  (shift_stb),
    .din  (ser_in),
    .q    (shift_bits)
  );

  sipo_hold_reg #(.W(W)) u_hold (
    .clk  (clk),
    .live (live_vec[1]),
    .load (store_stb),
    .d    (shift_bits),
    .q    (par_out)
  );

  assign casc_out = shift_bits[TOP_BIT];
endmodule

// File: rtl/sipo_latch_chk.sv
module sipo_latch_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         shift_clr_n,
  input logic         store_clr_n,
  input logic         ser_in,
  input logic         shift_stb,
  input logic         store_stb,
  input logic         shift_live,
  input logic         store_live,
  input logic [W-1:0] stage_q,
  input logic [W-1:0] par_out,
  input logic         casc_out
);
  AST_SHIFT_CLR_EMPTY: assert property (@(posedge clk) disable iff (!store_clr_n)
    !shift_clr_n |-> (casc_out == 1'b0)); // R5

  AST_STORE_CLR_EMPTY: assert property (@(posedge clk) disable iff (!shift_clr_n)
    !store_clr_n |-> (par_out == '0)); // R6

  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!store_clr_n)
    !store_stb |=> $stable(par_out)); // R4

  AST_CASC_STEADY: assert property (@(posedge clk) disable iff (!shift_clr_n)
    !shift_stb |=> $stable(casc_out)); // R3

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!shift_clr_n)
    (shift_stb && shift_live) |=> (stage_q == {$past(stage_q[W-2:0]), $past(ser_in)})); // R2

  AST_LOAD_PRE_EDGE: assert property (@(posedge clk) disable iff (!shift_clr_n || !store_clr_n)
    (store_stb && store_live) |=> (par_out == $past(stage_q))); // R8

  AST_SHIFT_IDLE_CLR: assert property (@(posedge clk) disable iff (!shift_clr_n)
    !shift_live |=> (stage_q == '0)); // R9
endmodule

bind sipo_latch_top sipo_latch_chk #(.W(W)) u_chk (
  .clk         (clk),
  .shift_clr_n (shift_clr_n),
  .store_clr_n (store_clr_n),
  .ser_in      (ser_in),
  .shift_stb   (shift_stb),
  .store_stb   (store_stb),
  .shift_live  (live_vec[0]),
  .store_live  (live_vec[1]),
  .stage_q     (shift_bits),
  .par_out     (par_out),
  .casc_out    (casc_out)
);

// File: tb/sipo_latch_top_test.sv
`timescale 1ns/1ps
module sipo_latch_top_test;
  logic       clk = 1'b0;
  logic       shift_clr_n = 1'b0;
  logic       store_clr_n = 1'b0;
  logic       ser_in = 1'b0;
  logic       shift_stb = 1'b0;
  logic       store_stb = 1'b0;
  logic [7:0] par_a, par_b;
  logic       casc_a, casc_b;

  int n_cmp = 0;
  int n_bad = 0;

  // bench reference: shift contents and expected outputs of both devices
  logic [7:0] ma = '0, mb = '0, pa = '0, pb = '0;
  logic       sh_ok = 1'b0, st_ok = 1'b0;

  always #2.5 clk = ~clk;

  sipo_latch_top uut (
    .clk(clk), .shift_clr_n(shift_clr_n), .store_clr_n(store_clr_n),
    .ser_in(ser_in), .shift_stb(shift_stb), .store_stb(store_stb),
    .par_out(par_a), .casc_out(casc_a)
  );

  sipo_latch_top uut_b (
    .clk(clk), .shift_clr_n(shift_clr_n), .store_clr_n(store_clr_n),
    .ser_in(casc_a), .shift_stb(shift_stb), .store_stb(store_stb),
    .par_out(par_b), .casc_out(casc_b)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic d, input logic sh, input logic st);
    ser_in = d; shift_stb = sh; store_stb = st;
    @(posedge clk);
    if (st && st_ok) begin pa = ma; pb = mb; end
    if (sh && sh_ok) begin mb = {mb[6:0], ma[7]}; ma = {ma[6:0], d}; end
    #1;
    shift_stb = 1'b0; store_stb = 1'b0;
  endtask

  function automatic logic [15:0] word_of(input int i);
    if (i < 16)      return 16'(1) << i;
    else if (i < 32) return ~(16'(1) << (i - 16));
    else             return 16'(i * 40503) ^ 16'(i << 5);
  endfunction

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 par_a", {8'h00, par_a}, 16'h0000);
    chk("R1 par_b", {8'h00, par_b}, 16'h0000);
    chk("R1 casc", {15'd0, casc_a}, 16'h0000);

    shift_clr_n = 1'b1; store_clr_n = 1'b1;
    step(0, 0, 0); step(0, 0, 0);
    sh_ok = 1'b1; st_ok = 1'b1;
    prev = 16'h0000;

    // R2/R3/R4 sweep through the two-device chain
    for (int i = 0; i < 256; i++) begin
      logic [15:0] w;
      w = word_of(i);
      for (int k = 0; k < 16; k++) step(w[15-k], 1, 0);
      chk("R4 hold before store", {par_b, par_a}, prev);
      chk("R3 cascade is top stage", {15'd0, casc_a}, {15'd0, w[7]});
      step(0, 0, 1);
      chk("R2 chained word", {par_b, par_a}, w);
      prev = w;
    end

    // R8 same-edge shift and store
    step(1, 1, 0); step(0, 1, 0); step(1, 1, 0);
    step(1, 1, 1);
    chk("R8 store takes pre-edge chain", {par_b, par_a}, {pb, pa});
    step(0, 0, 1);
    chk("R8 chain advanced", {par_b, par_a}, {pb, pa});

    // R5 shift clear, R9 strobe ignored, R7 zero load
    step(1, 1, 0);
    prev = {par_b, par_a};
    shift_clr_n = 1'b0;
    #1;
    chk("R5 cascade cleared", {15'd0, casc_a}, 16'h0000);
    chk("R5 output untouched", {par_b, par_a}, prev);
    sh_ok = 1'b0; ma = '0; mb = '0;
    step(1, 1, 0);
    chk("R9 shift ignored while cleared", {15'd0, casc_a}, 16'h0000);
    step(0, 0, 1);
    chk("R7 store of cleared chain", {par_b, par_a}, 16'h0000);

    // R10 release timing
    shift_clr_n = 1'b1;
    step(1, 1, 0); step(1, 1, 0);
    sh_ok = 1'b1;
    step(1, 1, 0);
    step(0, 0, 1);
    chk("R10 first shift after release", {par_b, par_a}, 16'h0001);

    // R6 store clear leaves chain intact
    for (int k = 0; k < 8; k++) step(k[0] ^ k[2], 1, 0);
    step(0, 0, 1);
    chk("R6 pre-clear load", {par_b, par_a}, {pb, pa});
    store_clr_n = 1'b0;
    #1;
    chk("R6 output cleared", {par_b, par_a}, 16'h0000);
    chk("R6 chain untouched", {15'd0, casc_a}, {15'd0, ma[7]});
    st_ok = 1'b0;
    step(0, 0, 1);
    chk("R9 store ignored while cleared", {par_b, par_a}, 16'h0000);
    store_clr_n = 1'b1;
    step(0, 0, 0); step(0, 0, 0);
    st_ok = 1'b1;
    step(0, 0, 1);
    chk("R6 chain shown after release", {par_b, par_a}, {mb, ma});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule